// File: doc/BRIEF.md
# Critical-Section Write/Invalidate Entry Tracker

This block sits beside a private L1 data cache in a machine whose caches are not kept coherent by hardware. Software brackets a short region of code, typically a lock-protected critical section, with a region-start and a region-end strobe. While the region is open, the tracker keeps two small lists. The write list holds the cache position (set index and way) of every line that takes a store hit. The invalidate list holds the tags of lines already self-invalidated in the region.

When the region closes, the tracker walks the write list and sends the cache controller one targeted line writeback per cycle, oldest first, then pulses a completion strobe. The whole cache is never flushed in this case. A repeated store to a line already listed adds nothing. Invalidate requests pass through to the controller unless the same tag was already invalidated in the open region; such repeats are dropped.

Either list can run out of room. A full write list sets a flag, and the region end then issues a single whole-cache writeback instead of a list walk. A full invalidate list sets its own flag and from then on simply forwards every invalidate it cannot match. Both lists and both flags are emptied when a region opens and again when its end sequence completes.

Top module: `cs_track`

## Requirements
- R1: During and right after reset, all command outputs (`wbValid`, `wbAll`, `invValid`, `drainDone`) are low, `wbSet`/`wbWay`/`invTagOut` are zero, and `inRegion`, `meOvf` and `ieOvf` are low.
- R2: `regionStart` sampled while idle makes `inRegion` high from the next cycle. `regionStart` sampled while a region is open or its end sequence is running has no effect. `regionEnd` sampled while idle produces no command and no `drainDone`.
- R3: Each store hit (`wrHit`) sampled while a region is open is recorded as a (set, way) pair. After `regionEnd` is sampled, recorded pairs appear on `wbSet`/`wbWay` with `wbValid` high, one per cycle in the order they were first recorded. The first one appears in the cycle after the `regionEnd` edge. `wbValid` is never high while `inRegion` is high.
- R4: A store hit whose (set, way) is already recorded in the open region adds no entry, so each distinct line is written back exactly once.
- R5: `drainDone` is a one-cycle pulse in the cycle after the last targeted writeback. With no entries recorded, it comes in the cycle right after the `regionEnd` edge.
- R6: Store hits sampled while no region is open are not recorded.
- R7: A distinct store hit that finds all ME_DEPTH (default 16) write entries in use sets `meOvf`. The region end then issues exactly one `wbAll` cycle, with no `wbValid`, in the cycle after the `regionEnd` edge, followed by `drainDone` in the next cycle.
- R8: An invalidate request (`invReq`) in an open region whose tag is not recorded appears on `invValid`/`invTagOut` in the next cycle, and the tag is recorded if room remains.
- R9: An invalidate request in an open region whose tag is already recorded produces no `invValid`.
- R10: An unmatched invalidate that finds all IE_DEPTH (default 4) invalidate entries in use sets `ieOvf` and is still forwarded. Its tag is not recorded, so a repeat of it is forwarded again.
- R11: Invalidate requests outside a region are always forwarded, one cycle later, with no filtering.
- R12: When `drainDone` pulses, both flags are low and both lists are empty. Lines recorded in an earlier region are neither written back nor filtered in a later one.
- R13: A store hit or invalidate sampled in the same cycle as an accepted `regionStart`, or in the same cycle as `regionEnd`, counts as inside the region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regionStart | input | 1 | Opens a tracked region (pulse) |
| regionEnd | input | 1 | Closes the region and starts the writeback walk (pulse) |
| wrHit | input | 1 | Store hit in the L1 this cycle |
| wrSet | input | SET_W | Set index of the store hit |
| wrWay | input | WAY_W | Way of the store hit |
| invReq | input | 1 | Self-invalidate request this cycle |
| invTag | input | TAG_W | Tag of the line to invalidate |
| wbValid | output | 1 | Targeted line writeback command |
| wbAll | output | 1 | Whole-cache writeback command |
| wbSet | output | SET_W | Set index of the targeted writeback |
| wbWay | output | WAY_W | Way of the targeted writeback |
| invValid | output | 1 | Invalidate command to the cache controller |
| invTagOut | output | TAG_W | Tag of the forwarded invalidate |
| drainDone | output | 1 | Region end sequence complete (pulse) |
| inRegion | output | 1 | A region is open |
| meOvf | output | 1 | Write list ran out of room in this region |
| ieOvf | output | 1 | Invalidate list ran out of room in this region |

## Verification
Two events can meet in a single cycle. A region boundary strobe can arrive together with a store hit or an invalidate, and a store hit can arrive together with the lookup of an identical pending entry. The bench opens a region with a store hit in the same cycle and closes it with another store hit and a repeated invalidate in the same cycle. It then expects both stores, in order, in the writeback walk, and no forwarded invalidate for the repeat. Duplicate store hits are mixed into a table of region writes, and the judgement rests on the exact sequence and count of writebacks and on the cycle of the completion pulse.

// File: rtl/cs_track_pkg.sv
`timescale 1ns/1ps
package cs_track_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DRAIN  = 2'd2
  } trackState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;     // empty both lists and flags this edge
    logic trackOn;   // record hits and filter invalidates this edge
    logic issueOne;  // emit the entry under the read pointer
    logic issueAll;  // emit a whole-cache writeback
    logic finish;    // end sequence complete, empty everything
  } trackStrobe_t;

endpackage

// File: rtl/cs_track_ctrl.sv
`timescale 1ns/1ps
module cs_track_ctrl
  import cs_track_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regionStart,
  input  logic         regionEnd,
  input  logic         drainEmpty,
  input  logic         meOvf,
  output trackStrobe_t stb,
  output logic         inRegion
);

  trackState_t state, stateNxt;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (regionStart) begin
          stb.clear   = 1'b1;
          stb.trackOn = 1'b1;
          stateNxt    = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        stb.trackOn = 1'b1;
        if (regionEnd) stateNxt = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (!drainEmpty) begin
          if (meOvf) stb.issueAll = 1'b1;
          else       stb.issueOne = 1'b1;
        end else begin
          stb.finish = 1'b1;
          stateNxt   = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign inRegion = (state == ST_ACTIVE);

endmodule

// File: rtl/cs_track_dp.sv
`timescale 1ns/1ps
module cs_track_dp
  import cs_track_pkg::*;
#(
  parameter int ME_DEPTH = 16,
  parameter int IE_DEPTH = 4,
  parameter int SET_W    = 6,
  parameter int WAY_W    = 2,
  parameter int TAG_W    = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  trackStrobe_t     stb,
  input  logic             wrHit,
  input  logic [SET_W-1:0] wrSet,
  input  logic [WAY_W-1:0] wrWay,
  input  logic             invReq,
  input  logic [TAG_W-1:0] invTag,
  output logic             drainEmpty,
  output logic             meOvf,
  output logic             ieOvf,
  output logic             wbValid,
  output logic             wbAll,
  output logic [SET_W-1:0] wbSet,
  output logic [WAY_W-1:0] wbWay,
  output logic             invValid,
  output logic [TAG_W-1:0] invTagOut,
  output logic             drainDone
);

  localparam int LOC_W    = SET_W + WAY_W;
  localparam int ME_CNT_W = $clog2(ME_DEPTH + 1);
  localparam int IE_CNT_W = $clog2(IE_DEPTH + 1);

  // ---------------- write list ----------------
  logic [LOC_W-1:0]    meLoc [ME_DEPTH];
  logic [ME_CNT_W-1:0] meCnt, meCntEff, rdPtr;
  logic [ME_DEPTH-1:0] meMatch;
  logic [LOC_W-1:0]    wrLoc, rdLoc;
  logic                meHit, meRec, meRoom, mePut;

  assign wrLoc = {wrSet, wrWay};

  for (genvar i = 0; i < ME_DEPTH; i++) begin : g_meCmp
    assign meMatch[i] = !stb.clear && (ME_CNT_W'(i) < meCnt) && (meLoc[i] == wrLoc);
  end

  assign meHit    = |meMatch;
  assign meCntEff = stb.clear ? '0 : meCnt;
  assign meRoom   = meCntEff < ME_CNT_W'(ME_DEPTH);
  assign meRec    = stb.trackOn && wrHit && !meHit;
  assign mePut    = meRec && meRoom;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ME_DEPTH; i++) meLoc[i] <= '0;
    end else begin
      for (int i = 0; i < ME_DEPTH; i++)
        if (mePut && meCntEff == ME_CNT_W'(i)) meLoc[i] <= wrLoc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          meCnt <= '0;
    else if (stb.finish) meCnt <= '0;
    else if (mePut)     meCnt <= meCntEff + 1'b1;
    else if (stb.clear) meCnt <= '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      meOvf <= 1'b0;
    else if (stb.finish || stb.clear) meOvf <= 1'b0;
    else if (meRec && !meRoom)      meOvf <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdPtr <= '0;
    else if (stb.finish)   rdPtr <= '0;
    else if (stb.issueAll) rdPtr <= meCnt;
    else if (stb.issueOne) rdPtr <= rdPtr + 1'b1;
  end

  always_comb begin
    rdLoc = '0;
    for (int i = 0; i < ME_DEPTH; i++)
      if (rdPtr == ME_CNT_W'(i)) rdLoc = meLoc[i];
  end

  assign drainEmpty = (rdPtr == meCnt);

  // ---------------- invalidate list ----------------
  logic [TAG_W-1:0]    ieTag [IE_DEPTH];
  logic [IE_CNT_W-1:0] ieCnt, ieCntEff;
  logic [IE_DEPTH-1:0] ieMatch;
  logic                ieHit, ieRec, ieRoom, iePut, invPass;

  for (genvar j = 0; j < IE_DEPTH; j++) begin : g_ieCmp
    assign ieMatch[j] = !stb.clear && (IE_CNT_W'(j) < ieCnt) && (ieTag[j] == invTag);
  end

  assign ieHit    = |ieMatch;
  assign ieCntEff = stb.clear ? '0 : ieCnt;
  assign ieRoom   = ieCntEff < IE_CNT_W'(IE_DEPTH);
  assign ieRec    = stb.trackOn && invReq && !ieHit;
  assign iePut    = ieRec && ieRoom;
  assign invPass  = invReq && (!stb.trackOn || !ieHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < IE_DEPTH; j++) ieTag[j] <= '0;
    end else begin
      for (int j = 0; j < IE_DEPTH; j++)
        if (iePut && ieCntEff == IE_CNT_W'(j)) ieTag[j] <= invTag;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ieCnt <= '0;
    else if (stb.finish) ieCnt <= '0;
    else if (iePut)     ieCnt <= ieCntEff + 1'b1;
    else if (stb.clear) ieCnt <= '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      ieOvf <= 1'b0;
    else if (stb.finish || stb.clear) ieOvf <= 1'b0;
    else if (ieRec && !ieRoom)      ieOvf <= 1'b1;
  end

  // ---------------- command registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbValid   <= 1'b0;
      wbAll     <= 1'b0;
      wbSet     <= '0;
      wbWay     <= '0;
      invValid  <= 1'b0;
      invTagOut <= '0;
      drainDone <= 1'b0;
    end else begin
      wbValid        <= stb.issueOne;
      wbAll          <= stb.issueAll;
      {wbSet, wbWay} <= stb.issueOne ? rdLoc : '0;
      invValid       <= invPass;
      invTagOut      <= invPass ? invTag : '0;
      drainDone      <= stb.finish;
    end
  end

endmodule

// File: rtl/cs_track.sv
`timescale 1ns/1ps
module cs_track
  import cs_track_pkg::*;
#(
  parameter int ME_DEPTH = 16,
  parameter int IE_DEPTH = 4,
  parameter int SET_W    = 6,
  parameter int WAY_W    = 2,
  parameter int TAG_W    = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regionStart,
  input  logic             regionEnd,
  input  logic             wrHit,
  input  logic [SET_W-1:0] wrSet,
  input  logic [WAY_W-1:0] wrWay,
  input  logic             invReq,
  input  logic [TAG_W-1:0] invTag,
  output logic             wbValid,
  output logic             wbAll,
  output logic [SET_W-1:0] wbSet,
  output logic [WAY_W-1:0] wbWay,
  output logic             invValid,
  output logic [TAG_W-1:0] invTagOut,
  output logic             drainDone,
  output logic             inRegion,
  output logic             meOvf,
  output logic             ieOvf
);

  trackStrobe_t stb;
  logic         drainEmpty;

  cs_track_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .regionStart(regionStart),
    .regionEnd  (regionEnd),
    .drainEmpty (drainEmpty),
    .meOvf      (meOvf),
    .stb        (stb),
    .inRegion   (inRegion)
  );

  cs_track_dp #(
    .ME_DEPTH(ME_DEPTH),
    .IE_DEPTH(IE_DEPTH),
    .SET_W   (SET_W),
    .WAY_W   (WAY_W),
    .TAG_W   (TAG_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrHit     (wrHit),
    .wrSet     (wrSet),
    .wrWay     (wrWay),
    .invReq    (invReq),
    .invTag    (invTag),
    .drainEmpty(drainEmpty),
    .meOvf     (meOvf),
    .ieOvf     (ieOvf),
    .wbValid   (wbValid),
    .wbAll     (wbAll),
    .wbSet     (wbSet),
    .wbWay     (wbWay),
    .invValid  (invValid),
    .invTagOut (invTagOut),
    .drainDone (drainDone)
  );

endmodule

// File: rtl/cs_track_chk.sv
`timescale 1ns/1ps
module cs_track_chk (
  input logic clk,
  input logic rstN,
  input logic regionStart,
  input logic wbValid,
  input logic wbAll,
  input logic drainDone,
  input logic inRegion,
  input logic meOvf,
  input logic ieOvf
);

  // R3
  wb_outside_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> !inRegion);

  // R7
  all_then_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbAll |=> drainDone);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    drainDone |=> !drainDone);

  // R5
  cmd_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wbValid, wbAll, drainDone}));

  // R12
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    drainDone |-> (!meOvf && !ieOvf));

  // R2
  start_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inRegion) |-> $past(regionStart));

endmodule

bind cs_track cs_track_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .regionStart(regionStart),
  .wbValid    (wbValid),
  .wbAll      (wbAll),
  .drainDone  (drainDone),
  .inRegion   (inRegion),
  .meOvf      (meOvf),
  .ieOvf      (ieOvf)
);

// File: tb/cs_track_tb_top.sv
`timescale 1ns/1ps
module cs_track_tb_top;

  localparam int SET_W = 6;
  localparam int WAY_W = 2;
  localparam int TAG_W = 20;
  localparam int ME_DEPTH = 16;

  logic             clk = 1'b0;
  logic             rstN;
  logic             regionStart, regionEnd, wrHit, invReq;
  logic [SET_W-1:0] wrSet;
  logic [WAY_W-1:0] wrWay;
  logic [TAG_W-1:0] invTag;
  logic             wbValid, wbAll, invValid, drainDone, inRegion, meOvf, ieOvf;
  logic [SET_W-1:0] wbSet;
  logic [WAY_W-1:0] wbWay;
  logic [TAG_W-1:0] invTagOut;

  always #2.5 clk = ~clk;

  cs_track dut_i (
    .clk(clk), .rstN(rstN), .regionStart(regionStart), .regionEnd(regionEnd),
    .wrHit(wrHit), .wrSet(wrSet), .wrWay(wrWay), .invReq(invReq), .invTag(invTag),
    .wbValid(wbValid), .wbAll(wbAll), .wbSet(wbSet), .wbWay(wbWay),
    .invValid(invValid), .invTagOut(invTagOut), .drainDone(drainDone),
    .inRegion(inRegion), .meOvf(meOvf), .ieOvf(ieOvf)
  );

  int total = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // write table: {dup, set, way}; dup rows repeat an earlier line
  localparam logic [SET_W+WAY_W:0] WR_TAB [10] = '{
    {1'b0, 6'd3,  2'd1}, {1'b0, 6'd10, 2'd0}, {1'b1, 6'd3,  2'd1},
    {1'b0, 6'd3,  2'd2}, {1'b0, 6'd63, 2'd3}, {1'b1, 6'd10, 2'd0},
    {1'b0, 6'd0,  2'd0}, {1'b1, 6'd63, 2'd3}, {1'b0, 6'd33, 2'd1},
    {1'b1, 6'd3,  2'd2}
  };

  logic [SET_W-1:0] gotSet [32];
  logic [WAY_W-1:0] gotWay [32];
  logic [SET_W-1:0] expSet [32];
  logic [WAY_W-1:0] expWay [32];
  int nWb, nAll, doneCyc;
  bit endInv;

  task automatic drainRun();
    regionEnd = 1'b1;
    tick();
    regionEnd = 1'b0;
    endInv = invValid;
    wrHit = 1'b0;
    invReq = 1'b0;
    nWb = 0; nAll = 0; doneCyc = -1;
    for (int c = 1; c <= 40; c++) begin
      tick();
      if (wbValid) begin
        gotSet[nWb] = wbSet;
        gotWay[nWb] = wbWay;
        nWb++;
      end
      if (wbAll) nAll++;
      if (drainDone) begin
        doneCyc = c;
        break;
      end
    end
  endtask

  task automatic openRegion();
    regionStart = 1'b1;
    tick();
    regionStart = 1'b0;
  endtask

  task automatic doWrite(input int s, input int w);
    wrHit = 1'b1; wrSet = SET_W'(s); wrWay = WAY_W'(w);
    tick();
    wrHit = 1'b0;
  endtask

  task automatic doInv(input int t);
    invReq = 1'b1; invTag = TAG_W'(t);
    tick();
    invReq = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    total++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int nExp;
    rstN = 1'b0;
    regionStart = 0; regionEnd = 0; wrHit = 0; invReq = 0;
    wrSet = '0; wrWay = '0; invTag = '0;
    repeat (3) tick();
    // R1 reset state
    chk({wbValid, wbAll, invValid, drainDone, inRegion, meOvf, ieOvf} == 0 &&
        wbSet == 0 && wbWay == 0 && invTagOut == 0, "R1 reset outputs",
        int'({wbValid, wbAll, invValid, drainDone, inRegion, meOvf, ieOvf}), 0);
    rstN = 1'b1;
    tick();
    chk({wbValid, wbAll, invValid, drainDone, inRegion} == 0, "R1 after release",
        int'({wbValid, wbAll, invValid, drainDone, inRegion}), 0);

    // table walk: R3 R4 R5 R2
    openRegion();
    chk(inRegion == 1'b1, "R2 region opens", int'(inRegion), 1);
    nExp = 0;
    for (int r = 0; r < 10; r++) begin
      if (!WR_TAB[r][SET_W+WAY_W]) begin
        expSet[nExp] = WR_TAB[r][SET_W+WAY_W-1:WAY_W];
        expWay[nExp] = WR_TAB[r][WAY_W-1:0];
        nExp++;
      end
      doWrite(int'(WR_TAB[r][SET_W+WAY_W-1:WAY_W]), int'(WR_TAB[r][WAY_W-1:0]));
      chk(!wbValid && !wbAll, "R3 no writeback inside region", int'(wbValid), 0);
      if (r == 4) begin
        regionStart = 1'b1; // R2 must be ignored while open
        tick();
        regionStart = 1'b0;
      end
    end
    drainRun();
    chk(nWb == nExp, "R4 distinct writeback count", nWb, nExp);
    for (int k = 0; k < nExp; k++)
      chk(gotSet[k] == expSet[k] && gotWay[k] == expWay[k], "R3 writeback order",
          int'({gotSet[k], gotWay[k]}), int'({expSet[k], expWay[k]}));
    chk(doneCyc == nExp + 1, "R5 done cycle", doneCyc, nExp + 1);
    tick();
    chk(!drainDone && !inRegion, "R5 done is a pulse", int'(drainDone), 0);

    // R6 outside write, R5 empty region, R2 end while idle
    doWrite(12, 1);
    openRegion();
    drainRun();
    chk(nWb == 0 && nAll == 0, "R6 outside write not recorded", nWb, 0);
    chk(doneCyc == 1, "R5 empty region done", doneCyc, 1);
    regionEnd = 1'b1;
    tick();
    regionEnd = 1'b0;
    tick();
    chk(!drainDone && !wbValid && !wbAll, "R2 end while idle ignored", int'(drainDone), 0);

    // R7 write list overflow
    openRegion();
    for (int i = 0; i <= ME_DEPTH; i++) doWrite(i, i % 4);
    chk(meOvf == 1'b1, "R7 overflow flag", int'(meOvf), 1);
    drainRun();
    chk(nAll == 1 && nWb == 0, "R7 single whole-cache writeback", nAll, 1);
    chk(doneCyc == 2, "R7 done after whole-cache", doneCyc, 2);
    chk(!meOvf && !ieOvf, "R12 flags cleared", int'(meOvf), 0);

    // R8 R9 R10 invalidate list
    openRegion();
    doInv(100);
    chk(invValid && invTagOut == 100, "R8 first invalidate forwarded", int'(invTagOut), 100);
    doInv(100);
    chk(!invValid, "R9 repeat invalidate dropped", int'(invValid), 0);
    doInv(101); doInv(102); doInv(103);
    chk(invValid && invTagOut == 103 && !ieOvf, "R8 fourth invalidate", int'(invTagOut), 103);
    doInv(104);
    chk(invValid && invTagOut == 104, "R10 overflow still forwarded", int'(invTagOut), 104);
    chk(ieOvf == 1'b1, "R10 overflow flag", int'(ieOvf), 1);
    doInv(104);
    chk(invValid, "R10 unrecorded tag forwarded again", int'(invValid), 1);
    doInv(101);
    chk(!invValid, "R9 recorded tag still dropped", int'(invValid), 0);
    drainRun();
    chk(doneCyc == 1 && !ieOvf, "R12 invalidate flag cleared", int'(ieOvf), 0);

    // R11 outside region pass-through
    doInv(100);
    chk(invValid && invTagOut == 100, "R11 outside forward 1", int'(invValid), 1);
    doInv(100);
    chk(invValid && invTagOut == 100, "R11 outside forward 2", int'(invValid), 1);

    // R12 fresh lists in a new region
    openRegion();
    doInv(100);
    chk(invValid, "R12 old tag not filtered", int'(invValid), 1);
    doWrite(9, 3);
    drainRun();
    chk(nWb == 1 && gotSet[0] == 9 && gotWay[0] == 3, "R12 only new entry written back",
        nWb, 1);

    // R13 coincident boundary events
    wrHit = 1'b1; wrSet = 6'd5; wrWay = 2'd1;
    openRegion();
    wrHit = 1'b0;
    doInv(200);
    wrHit = 1'b1; wrSet = 6'd7; wrWay = 2'd2;
    invReq = 1'b1; invTag = 20'd200;
    drainRun();
    chk(!endInv, "R13 invalidate at end filtered", int'(endInv), 0);
    chk(nWb == 2, "R13 boundary writes count", nWb, 2);
    chk(gotSet[0] == 5 && gotWay[0] == 1 && gotSet[1] == 7 && gotWay[1] == 2,
        "R13 boundary writes order", int'(gotSet[1]), 7);

    finishRun();
  end

endmodule